// File: doc/BRIEF.md
# Logical Shifter with Carry Flag

This block moves a 32-bit word left or right by a count between 0 and 255, filling the vacated positions with zeros. It also works out the bit that leaves the word last, which becomes the new carry. The data path is combinational: the shifted word and the proposed next carry follow the inputs in the same cycle. A one-bit flag register holds the carry and loads the proposed value on a rising clock edge only while flag update is requested.

The shift count is wider than the word index, so counts of a full word and beyond are decoded explicitly. The carry rules separate five cases: no shift, a partial shift, a shift of exactly one word, a shift past one word, and updates that are switched off. Every count from 33 to 255 behaves like 33. The block has no streaming interface, because it holds no data between cycles. There is no valid/ready handshake and so no back-pressure. Every pin is a plain level.

Top module: `lshift_unit`

## Requirements
- R1: With `dir_left` = 0 (right) and a count n from 1 to 31, `result[31-n:0]` equals `operand[31:n]` and the upper n bits of `result` are zero.
- R2: With `dir_left` = 1 (left) and a count n from 1 to 31, `result[31:n]` equals `operand[31-n:0]` and the lower n bits of `result` are zero.
- R3: Any count from 32 to 255, in either direction, gives `result` equal to zero.
- R4: A count of zero, in either direction, gives `result` equal to `operand` and leaves `carry_q` unchanged even when `flag_en` is 1.
- R5: With `flag_en` = 1, a right shift by n from 1 to 32 loads `carry_q` with `operand[n-1]` at the next rising edge (bit 31 when n is 32).
- R6: With `flag_en` = 1, a left shift by n from 1 to 32 loads `carry_q` with `operand[32-n]` at the next rising edge (bit 0 when n is 32).
- R7: With `flag_en` = 1, any count from 33 to 255 clears `carry_q` at the next rising edge, in either direction.
- R8: With `flag_en` = 0, `carry_q` keeps its value across the edge for every count, direction and operand.
- R9: `rst` is synchronous and active high and clears `carry_q` to 0 at the next rising edge. Otherwise `carry_q` takes the value shown on `carry_next` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the carry register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the carry register |
| operand | input | 32 | Word to be shifted |
| amount | input | 8 | Shift count, 0 to 255 |
| dir_left | input | 1 | 1 shifts left, 0 shifts right |
| flag_en | input | 1 | 1 lets the shift update the carry |
| result | output | 32 | Shifted word, zero-filled |
| carry_next | output | 1 | Carry value the register takes at the next edge when enabled |
| carry_q | output | 1 | Current carry flag |

## Verification
The bench builds the block with its default widths: a 32-bit word and an 8-bit count. With these widths the full count range, 0 through 255, is a small enough space to sweep completely in each direction, with flag update on and off, for several operands. This sweep reaches the exact-one-word count, where the carry comes from an end bit, and it covers every count above it, all of which must clear the carry. Directed steps first set the carry to 1. Holding a 1 is the only way to tell a kept carry from a cleared one, so the zero-count, disabled-update and reset cases are all checked from that state.

// File: rtl/lshift_pkg.sv
package lshift_pkg;
  typedef enum logic {
    SH_RIGHT = 1'b0,
    SH_LEFT  = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/lshift_barrel.sv
// Zero-filling barrel shifter; one stage per bit of the word-index part of the count.
module lshift_barrel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              to_left,
  output logic [DATA_W-1:0] dout
);
  localparam int STG = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [STG:0][DATA_W-1:0] stage;
  logic                     overrun;

  assign stage[0] = din;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    assign stage[k+1] = !amt[k] ? stage[k]
                      : (to_left ? (stage[k] << (2**k)) : (stage[k] >> (2**k)));
  end

  // Counts of a full word or more push every bit out.
  assign overrun = (amt >= FULL);
  assign dout    = overrun ? '0 : stage[STG];
endmodule

// File: rtl/lshift_carry.sv
// Picks the last bit shifted out; decides when the carry is kept or cleared.
module lshift_carry #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  logic              to_left,
  input  logic              upd_en,
  input  logic              cur_carry,
  output logic              nxt_carry
);
  localparam int STG = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);
  localparam logic [STG-1:0]   ONE  = STG'(1);

  logic [STG-1:0] low;
  logic [STG-1:0] idx;

  // For n in 1..DATA_W the low bits wrap so that n = DATA_W maps to 0:
  // right takes bit n-1, left takes bit DATA_W-n.
  assign low = amt[STG-1:0];
  assign idx = to_left ? (STG'(0) - low) : (low - ONE);

  always_comb begin
    nxt_carry = cur_carry;
    if (upd_en && (amt != '0)) begin
      if (amt > FULL) nxt_carry = 1'b0;
      else            nxt_carry = din[idx];
    end
  end
endmodule

// File: rtl/lshift_flag_reg.sv
module lshift_flag_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/lshift_unit.sv
module lshift_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  input  logic              dir_left,
  input  logic              flag_en,
  output logic [DATA_W-1:0] result,
  output logic              carry_next,
  output logic              carry_q
);
  import lshift_pkg::*;

  shift_dir_e dir;
  logic       go_left;

  assign dir     = shift_dir_e'(dir_left);
  assign go_left = (dir == SH_LEFT);

  lshift_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .din     (operand),
    .amt     (amount),
    .to_left (go_left),
    .dout    (result)
  );

  lshift_carry #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_carry (
    .din       (operand),
    .amt       (amount),
    .to_left   (go_left),
    .upd_en    (flag_en),
    .cur_carry (carry_q),
    .nxt_carry (carry_next)
  );

  lshift_flag_reg u_flag (
    .clk (clk),
    .rst (rst),
    .en  (flag_en),
    .d   (carry_next),
    .q   (carry_q)
  );
endmodule

// File: rtl/lshift_unit_chk.sv
module lshift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] operand,
  input logic [AMT_W-1:0]  amount,
  input logic              dir_left,
  input logic              flag_en,
  input logic [DATA_W-1:0] result,
  input logic              carry_next,
  input logic              carry_q
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  // R4
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (amount == '0) |-> (result == operand));

  // R4
  zero_amt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && amount == '0) |=> (carry_q == $past(carry_q)));

  // R3
  wide_amt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (amount >= FULL) |-> (result == '0));

  // R5
  right_full_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && !dir_left && amount == FULL) |=> (carry_q == $past(operand[DATA_W-1])));

  // R6
  left_full_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && dir_left && amount == FULL) |=> (carry_q == $past(operand[0])));

  // R7
  past_full_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && amount > FULL) |=> !carry_q);

  // R8
  hold_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> (carry_q == $past(carry_q)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !carry_q);

  // R9
  load_next_chk: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> (carry_q == $past(carry_next)));
endmodule

bind lshift_unit lshift_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .operand    (operand),
  .amount     (amount),
  .dir_left   (dir_left),
  .flag_en    (flag_en),
  .result     (result),
  .carry_next (carry_next),
  .carry_q    (carry_q)
);

// File: tb/lshift_unit_bench.sv
`timescale 1ns/1ps
module lshift_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic [7:0]  amount = '0;
  logic        dir_left = 1'b0;
  logic        flag_en = 1'b0;
  logic [31:0] result;
  logic        carry_next;
  logic        carry_q;

  always #2 clk = ~clk;

  lshift_unit u_lshift_unit (
    .clk(clk), .rst(rst), .operand(operand), .amount(amount),
    .dir_left(dir_left), .flag_en(flag_en), .result(result),
    .carry_next(carry_next), .carry_q(carry_q)
  );

  typedef struct packed {
    logic [31:0] res;
    logic        cy;
    logic [7:0]  amt;
    logic        left;
    logic        en;
    logic        rs;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  logic  model_cy = 1'b0;
  bit    done = 1'b0;

  function automatic string res_tag(input logic [7:0] n, input logic left);
    if (n == 0)  return "R4";
    if (n >= 32) return "R3";
    return left ? "R2" : "R1";
  endfunction

  function automatic string cy_tag(input item_t it);
    if (it.rs)        return "R9";
    if (!it.en)       return "R8";
    if (it.amt == 0)  return "R4";
    if (it.amt > 32)  return "R7";
    return it.left ? "R6" : "R5";
  endfunction

  task automatic drive(input logic [31:0] op, input logic [7:0] n,
                       input logic left, input logic en, input logic r);
    item_t it;
    logic  ec;
    @(negedge clk);
    operand = op; amount = n; dir_left = left; flag_en = en; rst = r;
    if (r)             ec = 1'b0;
    else if (!en)      ec = model_cy;
    else if (n == 0)   ec = model_cy;
    else if (n > 32)   ec = 1'b0;
    else if (left)     ec = op[32 - int'(n)];
    else               ec = op[int'(n) - 1];
    model_cy = ec;
    it.res  = (n >= 32) ? 32'h0 : (left ? (op << n) : (op >> n));
    it.cy   = ec;
    it.amt  = n;
    it.left = left;
    it.en   = en;
    it.rs   = r;
    sb_q.push_back(it);
  endtask

  // Monitor: inputs are held until the next falling edge, so just after the
  // rising edge both the combinational word and the loaded carry are visible.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (result !== it.res) begin
          fails++;
          $display("FAIL %s result amt=%0d left=%0b: got %h expected %h",
                   res_tag(it.amt, it.left), it.amt, it.left, result, it.res);
        end
        checks++;
        if (carry_q !== it.cy) begin
          fails++;
          $display("FAIL %s carry amt=%0d left=%0b en=%0b: got %0b expected %0b",
                   cy_tag(it), it.amt, it.left, it.en, carry_q, it.cy);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] op;
    // R9 reset state
    drive(32'hFFFF_FFFF, 8'd5, 1'b1, 1'b1, 1'b1);
    drive(32'hFFFF_FFFF, 8'd5, 1'b1, 1'b1, 1'b1);
    // R5 full-word right shift takes bit 31
    drive(32'h8000_0001, 8'd32, 1'b0, 1'b1, 1'b0);
    // R4 zero count keeps a set carry, both directions
    drive(32'h0000_0000, 8'd0, 1'b1, 1'b1, 1'b0);
    drive(32'h0000_0000, 8'd0, 1'b0, 1'b1, 1'b0);
    // R8 disabled update keeps the set carry at a large count
    drive(32'h0000_0000, 8'd200, 1'b1, 1'b0, 1'b0);
    // R7 count past a word clears it
    drive(32'hFFFF_FFFF, 8'd33, 1'b1, 1'b1, 1'b0);
    // R6 full-word left shift takes bit 0
    drive(32'h0000_0001, 8'd32, 1'b1, 1'b1, 1'b0);
    // R9 mid-run reset clears a set carry
    drive(32'h0000_0000, 8'd0, 1'b0, 1'b0, 1'b1);
    drive(32'h0000_0002, 8'd2, 1'b0, 1'b1, 1'b0);
    drive(32'hFFFF_FFFF, 8'd255, 1'b0, 1'b1, 1'b0);
    // R1 R2 R3 sweep of every count, both directions, update on and off
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 256; n++) begin
        for (int d = 0; d < 2; d++) begin
          for (int e = 0; e < 2; e++) begin
            case (p)
              0: op = 32'hFFFF_FFFF;
              1: op = 32'h8000_0001;
              default: op = $urandom;
            endcase
            drive(op, 8'(n), 1'(d), 1'(e), 1'b0);
          end
        end
      end
    end
    @(negedge clk);
    flag_en = 1'b0;
    while (sb_q.size() > 0) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule